// File: doc/BRIEF.md
# Bus Target Cycle Controller

This block is the clocked control core of a target on a shared, multiplexed address/data parallel bus. A transaction begins when the initiator pulls the active-low transaction line low while the address and the bus command are on the bus. The controller loads the address counter and the command register in that same cycle. In the next cycle it checks the range-hit flags from an external address comparator against the memory or I/O space that the latched command selects. If they agree, the controller claims the transaction and steps through its data phases. On each completed phase it advances the address counter by one byte for I/O or by one word for memory. If the initiator is not ready, it holds the phase.

Most control outputs are combinational (Mealy). They reach the address counter and the command latch before the next rising edge. The claim line, the data-bus drive and capture enables and the per-lane write enables are registered, so the shared lines never see glitches. A transaction the target does not claim leaves every output quiet until the transaction line returns high.

Top module: `tgt_ctl_top`

## Requirements
- R1: While reset is high, and after it, until a transaction starts: `claim_n` is 1, `ad_drive_en`, `ad_capture_en` and `lane_we` are 0, and all six decoded command flags are 0, because the command register resets to the reserved code 0100.
- R2: The latched command is the value on `cmd_be_n[3:0]`, taken as is, and it decodes as follows. Read is set for 0010, 0110, 1010, 1100 and 1110. Write is set for 0011, 0111, 1011 and 1111. I/O is set for 0010 and 0011. Memory is set for 0110, 0111, 1100, 1110 and 1111. Configuration is set for 1010 and 1011. Interrupt acknowledge is set for 0000. Every other code sets no flag.
- R3: In idle, a low `txn_n` raises `addr_load` and `cmd_load` in that same cycle and raises no other control output.
- R4: In the first data phase, a match means (`io_hit` and I/O) or (`mem_hit` and memory). When there is a match, `init_rdy_n` is low and `txn_n` is high, the block asserts `phase_valid` without any increment and returns to idle.
- R5: In a claimed memory transaction, each completed phase with `txn_n` still low asserts `phase_valid` together with `inc_word`.
- R6: In a claimed I/O transaction, each completed phase with `txn_n` still low asserts `phase_valid` together with `inc_byte`.
- R7: During a claimed phase with `init_rdy_n` high, `phase_hold` is 1, and `phase_valid`, `inc_byte` and `inc_word` are 0. The phase then repeats in the next cycle.
- R8: Without a match, including configuration, interrupt acknowledge, reserved and dual-address codes, the block never claims. It stays silent until `txn_n` is high, then returns to idle.
- R9: `claim_n` is low in the cycle after each cycle in which the block claims (every claimed first or burst phase, waits included), and is high otherwise.
- R10: `ad_drive_en` is 1 in the cycle after a valid phase of a read command. `ad_capture_en` is 1 in the cycle after a valid phase of a write command. The two are never 1 at the same time.
- R11: `lane_we` equals the inverse of `cmd_be_n`, registered from a valid write phase, and is 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_n | input | 1 | Transaction active, low while a transaction runs |
| init_rdy_n | input | 1 | Initiator ready, low when the initiator can complete the phase |
| cmd_be_n | input | LANES | Command in the address phase, byte enables (active low) in data phases |
| io_hit | input | 1 | Latched address lies in the I/O range |
| mem_hit | input | 1 | Latched address lies in a memory range |
| addr_load | output | 1 | Load address counter |
| cmd_load | output | 1 | Load command register |
| inc_byte | output | 1 | Advance address counter by 1 |
| inc_word | output | 1 | Advance address counter by 4 |
| phase_hold | output | 1 | Current phase is extended by the initiator |
| phase_valid | output | 1 | Data transfers in this cycle |
| dec_rd | output | 1 | Decoded read command |
| dec_wr | output | 1 | Decoded write command |
| dec_io | output | 1 | Command targets I/O space |
| dec_mem | output | 1 | Command targets memory space |
| dec_cfg | output | 1 | Command targets configuration space |
| dec_intack | output | 1 | Interrupt acknowledge command |
| claim_n | output | 1 | Registered device-select, active low |
| ad_drive_en | output | 1 | Registered enable to drive the data bus |
| ad_capture_en | output | 1 | Registered enable to capture from the data bus |
| lane_we | output | LANES | Registered per-lane write enables |

## Verification
The bench builds the block with the default four byte lanes, so the command occupies the whole byte-enable field. All sixteen command codes, including the reserved and dual-address ones, can therefore reach the decoder and the claim check. Seeded random choices of transaction, ready, hit flags and lane patterns reach wait insertion in both the first and the burst phases. They also reach misses that are held for several cycles, and back-to-back transactions that start directly from a final phase. Directed cases add single and burst cycles in both spaces with waits, and unclaimed configuration and interrupt-acknowledge cycles.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_RESET = 4'b0100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_BURST = 2'd2,
        ST_MISS  = 2'd3
    } tgt_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic io;
        logic mem;
        logic cfg;
        logic intack;
    } cmd_dec_t;

    typedef struct packed {
        logic ld;
        logic ld_cmd;
        logic claim;
        logic valid;
        logic inc_b;
        logic inc_w;
        logic hold;
    } fsm_out_t;

    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] c);
        cmd_dec_t d;
        d = '0;
        case (c)
            4'b0000: d.intack = 1'b1;
            4'b0010: begin d.io  = 1'b1; d.rd = 1'b1; end
            4'b0011: begin d.io  = 1'b1; d.wr = 1'b1; end
            4'b0110: begin d.mem = 1'b1; d.rd = 1'b1; end
            4'b0111: begin d.mem = 1'b1; d.wr = 1'b1; end
            4'b1010: begin d.cfg = 1'b1; d.rd = 1'b1; end
            4'b1011: begin d.cfg = 1'b1; d.wr = 1'b1; end
            4'b1100: begin d.mem = 1'b1; d.rd = 1'b1; end
            4'b1110: begin d.mem = 1'b1; d.rd = 1'b1; end
            4'b1111: begin d.mem = 1'b1; d.wr = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tgt_cmd_reg.sv
module tgt_cmd_reg
    import tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CMD_W-1:0] cmd_in,
    output cmd_dec_t         dec
);

    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst)       cmd_q <= CMD_RESET;
        else if (load) cmd_q <= cmd_in;
    end

    always_comb dec = decode_cmd(cmd_q);

    // R2: the register captures the bus command exactly when loaded
    assert_cmd_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> cmd_q == $past(cmd_in));

    // R2: without a load the command is held
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cmd_q));

endmodule

// File: rtl/tgt_ctrl_fsm.sv
module tgt_ctrl_fsm
    import tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     txn_n,
    input  logic     init_rdy_n,
    input  logic     io_hit,
    input  logic     mem_hit,
    input  cmd_dec_t dec,
    output fsm_out_t o
);

    tgt_state_e st_q, st_d;
    logic       match;

    always_comb begin
        o     = '0;
        st_d  = st_q;
        match = (io_hit & dec.io) | (mem_hit & dec.mem);
        case (st_q)
            ST_IDLE: begin
                if (!txn_n) begin
                    o.ld     = 1'b1;
                    o.ld_cmd = 1'b1;
                    st_d     = ST_CHECK;
                end
            end
            ST_CHECK, ST_BURST: begin
                if (st_q == ST_CHECK && !match) begin
                    st_d = txn_n ? ST_IDLE : ST_MISS;
                end else begin
                    o.claim = 1'b1;
                    if (init_rdy_n) begin
                        o.hold = 1'b1;
                    end else begin
                        o.valid = 1'b1;
                        if (txn_n) begin
                            st_d = ST_IDLE;
                        end else begin
                            o.inc_w = dec.mem;
                            o.inc_b = dec.io;
                            st_d    = ST_BURST;
                        end
                    end
                end
            end
            ST_MISS: begin
                if (txn_n) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // R3: a load always leads into the address check state
    assert_load_to_check_R3: assert property (@(posedge clk) disable iff (rst)
        o.ld |=> st_q == ST_CHECK);

    // R4: a final valid phase returns the controller to idle
    assert_last_phase_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (o.valid && txn_n) |=> st_q == ST_IDLE);

    // R5: a word increment continues a burst
    assert_inc_word_burst_R5: assert property (@(posedge clk) disable iff (rst)
        o.inc_w |=> st_q == ST_BURST);

    // R6: increments and hold are mutually exclusive
    assert_inc_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({o.inc_b, o.inc_w, o.hold}));

    // R7: a held phase keeps its state
    assert_hold_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
        o.hold |=> $stable(st_q));

    // R8: nothing is claimed while waiting out a missed transaction
    assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MISS) |-> !o.claim && !o.valid);

endmodule

// File: rtl/tgt_xcvr_ctrl.sv
module tgt_xcvr_ctrl #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             claim,
    input  logic             valid,
    input  logic             rd,
    input  logic             wr,
    input  logic [LANES-1:0] be_n,
    output logic             claim_n,
    output logic             drive_en,
    output logic             capture_en,
    output logic [LANES-1:0] lane_we
);

    logic wr_phase;
    assign wr_phase = valid & wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            claim_n    <= 1'b1;
            drive_en   <= 1'b0;
            capture_en <= 1'b0;
        end else begin
            claim_n    <= ~claim;
            drive_en   <= valid & rd;
            capture_en <= wr_phase;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) lane_we[g] <= 1'b0;
            else     lane_we[g] <= wr_phase & ~be_n[g];
        end
    end

    // R10: the bus is never driven and captured at once
    assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
        !(drive_en && capture_en));

    // R9: claim line follows the claim request one cycle later
    assert_claim_follows_R9: assert property (@(posedge clk) disable iff (rst)
        claim |=> !claim_n);

    // R11: lane enables appear only behind a write capture
    assert_lane_needs_capture_R11: assert property (@(posedge clk) disable iff (rst)
        (lane_we != '0) |-> capture_en);

endmodule

// File: rtl/tgt_ctl_top.sv
module tgt_ctl_top
    import tgt_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_n,
    input  logic             init_rdy_n,
    input  logic [LANES-1:0] cmd_be_n,
    input  logic             io_hit,
    input  logic             mem_hit,
    output logic             addr_load,
    output logic             cmd_load,
    output logic             inc_byte,
    output logic             inc_word,
    output logic             phase_hold,
    output logic             phase_valid,
    output logic             dec_rd,
    output logic             dec_wr,
    output logic             dec_io,
    output logic             dec_mem,
    output logic             dec_cfg,
    output logic             dec_intack,
    output logic             claim_n,
    output logic             ad_drive_en,
    output logic             ad_capture_en,
    output logic [LANES-1:0] lane_we
);

    cmd_dec_t dec;
    fsm_out_t fo;

    tgt_cmd_reg u_cmd (
        .clk    (clk),
        .rst    (rst),
        .load   (fo.ld_cmd),
        .cmd_in (cmd_be_n[CMD_W-1:0]),
        .dec    (dec)
    );

    tgt_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .txn_n      (txn_n),
        .init_rdy_n (init_rdy_n),
        .io_hit     (io_hit),
        .mem_hit    (mem_hit),
        .dec        (dec),
        .o          (fo)
    );

    tgt_xcvr_ctrl #(.LANES(LANES)) u_xcvr (
        .clk        (clk),
        .rst        (rst),
        .claim      (fo.claim),
        .valid      (fo.valid),
        .rd         (dec.rd),
        .wr         (dec.wr),
        .be_n       (cmd_be_n),
        .claim_n    (claim_n),
        .drive_en   (ad_drive_en),
        .capture_en (ad_capture_en),
        .lane_we    (lane_we)
    );

    assign addr_load   = fo.ld;
    assign cmd_load    = fo.ld_cmd;
    assign inc_byte    = fo.inc_b;
    assign inc_word    = fo.inc_w;
    assign phase_hold  = fo.hold;
    assign phase_valid = fo.valid;
    assign dec_rd      = dec.rd;
    assign dec_wr      = dec.wr;
    assign dec_io      = dec.io;
    assign dec_mem     = dec.mem;
    assign dec_cfg     = dec.cfg;
    assign dec_intack  = dec.intack;

    // R1: the claim line is released while in reset
    assert_reset_release_R1: assert property (@(posedge clk)
        $past(rst) |-> claim_n);

endmodule

// File: tb/tb_tgt_ctl_top.sv
module tb_tgt_ctl_top;

    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst;
    logic txn_n, init_rdy_n, io_hit, mem_hit;
    logic [LANES-1:0] cmd_be_n;
    logic addr_load, cmd_load, inc_byte, inc_word, phase_hold, phase_valid;
    logic dec_rd, dec_wr, dec_io, dec_mem, dec_cfg, dec_intack;
    logic claim_n, ad_drive_en, ad_capture_en;
    logic [LANES-1:0] lane_we;

    always #4 clk = ~clk;

    tgt_ctl_top #(.LANES(LANES)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    // bench model state: 0 idle, 1 first phase, 2 burst, 3 miss
    int          ms;
    logic [3:0]  mc;
    logic        m_claim_n, m_drv, m_cap;
    logic [3:0]  m_lane;

    function automatic logic [5:0] exp_dec(input logic [3:0] c);
        logic rd, wr, io, mem, cfg, ia;
        rd  = (c == 4'b0010) || (c == 4'b0110) || (c == 4'b1010) || (c == 4'b1100) || (c == 4'b1110);
        wr  = (c == 4'b0011) || (c == 4'b0111) || (c == 4'b1011) || (c == 4'b1111);
        io  = (c == 4'b0010) || (c == 4'b0011);
        mem = (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) || (c == 4'b1110) || (c == 4'b1111);
        cfg = (c == 4'b1010) || (c == 4'b1011);
        ia  = (c == 4'b0000);
        return {rd, wr, io, mem, cfg, ia};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc_cnt, act, exp);
        end
    endtask

    task automatic cyc(input logic f, input logic i, input logic [3:0] be,
                       input logic ioh, input logic mh);
        logic [5:0] d;
        logic ld, claim, valid, ib, iw, hold, match;
        int nxt;
        @(negedge clk);
        txn_n = f; init_rdy_n = i; cmd_be_n = be; io_hit = ioh; mem_hit = mh;
        #1;
        // registered outputs from the previous edge
        chk(claim_n == m_claim_n, (ms == 3) ? "R8 R9" : "R9", {7'd0, claim_n}, {7'd0, m_claim_n});
        chk({ad_drive_en, ad_capture_en} == {m_drv, m_cap}, "R10",
            {6'd0, ad_drive_en, ad_capture_en}, {6'd0, m_drv, m_cap});
        chk(lane_we == m_lane, "R11", {4'd0, lane_we}, {4'd0, m_lane});
        d = exp_dec(mc);
        chk({dec_rd, dec_wr, dec_io, dec_mem, dec_cfg, dec_intack} == d, "R2",
            {2'd0, dec_rd, dec_wr, dec_io, dec_mem, dec_cfg, dec_intack}, {2'd0, d});
        ld = 0; claim = 0; valid = 0; ib = 0; iw = 0; hold = 0; nxt = ms;
        match = (ioh & d[3]) | (mh & d[2]);
        case (ms)
            0: if (!f) begin ld = 1; nxt = 1; end
            1, 2: begin
                if (ms == 1 && !match) nxt = f ? 0 : 3;
                else begin
                    claim = 1;
                    if (i) hold = 1;
                    else begin
                        valid = 1;
                        if (f) nxt = 0;
                        else begin iw = d[2]; ib = d[3]; nxt = 2; end
                    end
                end
            end
            default: if (f) nxt = 0;
        endcase
        chk({addr_load, cmd_load} == {ld, ld}, "R3", {6'd0, addr_load, cmd_load}, {6'd0, ld, ld});
        chk(phase_valid == valid, (ms == 3) ? "R8" : "R4", {7'd0, phase_valid}, {7'd0, valid});
        chk({inc_byte, inc_word} == {ib, iw}, d[3] ? "R6" : "R5",
            {6'd0, inc_byte, inc_word}, {6'd0, ib, iw});
        chk(phase_hold == hold, "R7", {7'd0, phase_hold}, {7'd0, hold});
        @(posedge clk);
        if (ld) mc = be;
        m_claim_n = ~claim;
        m_drv = valid & d[5];
        m_cap = valid & d[4];
        m_lane = (valid & d[4]) ? ~be : 4'd0;
        ms = nxt;
        cyc_cnt++;
    endtask

    always @(posedge clk) begin
        if (cyc_cnt > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; txn_n = 1'b1; init_rdy_n = 1'b1; cmd_be_n = 4'hF; io_hit = 0; mem_hit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state
        chk(claim_n && !ad_drive_en && !ad_capture_en && lane_we == 0, "R1",
            {4'd0, claim_n, ad_drive_en, ad_capture_en, 1'b0}, 8'h08);
        chk({dec_rd, dec_wr, dec_io, dec_mem, dec_cfg, dec_intack} == 6'd0, "R1",
            {2'd0, dec_rd, dec_wr, dec_io, dec_mem, dec_cfg, dec_intack}, 8'd0);
        rst = 1'b0;
        ms = 0; mc = 4'b0100; m_claim_n = 1; m_drv = 0; m_cap = 0; m_lane = 0;
        cyc(1, 1, 4'hF, 0, 0);

        // R4: single memory read with a hit
        cyc(0, 1, 4'b0110, 0, 0);
        cyc(1, 0, 4'b0000, 0, 1);
        cyc(1, 1, 4'hF, 0, 0);
        // R6 R7: I/O write burst with waits
        cyc(0, 1, 4'b0011, 0, 0);
        cyc(0, 1, 4'b1110, 1, 0);
        cyc(0, 0, 4'b1110, 1, 0);
        cyc(0, 1, 4'b1101, 0, 0);
        cyc(1, 0, 4'b1101, 0, 0);
        // R5: memory write-and-invalidate burst
        cyc(0, 1, 4'b1111, 0, 0);
        cyc(0, 0, 4'b0000, 0, 1);
        cyc(0, 0, 4'b0101, 0, 0);
        cyc(1, 0, 4'b0011, 0, 0);
        // R8: configuration read with both hits, not claimed
        cyc(0, 1, 4'b1010, 0, 0);
        cyc(0, 0, 4'b0000, 1, 1);
        cyc(0, 0, 4'b0000, 1, 1);
        cyc(1, 0, 4'b0000, 1, 1);
        // R8: interrupt acknowledge and dual address, not claimed
        cyc(0, 1, 4'b0000, 0, 0);
        cyc(1, 0, 4'b0000, 1, 1);
        cyc(0, 1, 4'b1101, 0, 0);
        cyc(0, 0, 4'b0000, 1, 1);
        cyc(1, 1, 4'hF, 0, 0);
        // R8: memory command with only the I/O range hit
        cyc(0, 1, 4'b0111, 0, 0);
        cyc(1, 0, 4'b0000, 1, 0);

        // constrained random mix
        for (int k = 0; k < 4000; k++) begin
            logic f, i;
            logic [3:0] be;
            f  = ($urandom_range(0, 99) < 55) ? 1'b0 : 1'b1;
            i  = ($urandom_range(0, 99) < 30) ? 1'b1 : 1'b0;
            be = 4'($urandom_range(0, 15));
            if (ms == 0 && $urandom_range(0, 3) != 0)
                be = ($urandom_range(0, 1) == 1) ? {3'b011, 1'($urandom_range(0, 1))}
                                                 : {3'b001, 1'($urandom_range(0, 1))};
            cyc(f, i, be, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        cyc(1, 1, 4'hF, 0, 0);
        cyc(1, 1, 4'hF, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule